// File: doc/BRIEF.md
# Sleep Wake-Up Reset Stretcher

This block is the always-on corner of a chip that stays powered while the core supply is off. Software asks for sleep with a one-cycle request. The block then drives the power-enable output low so the external regulator can shut down the core supply. While the chip sleeps, the block watches sixteen wake-capable external interrupt lines and an RTC alarm. The first rising edge on any of them ends the sleep. The block raises power-enable again and holds the core in reset for a fixed stretch of crystal-clock cycles. That reset behaves like an external cold reset, and it gives the supplies time to settle before the core runs.

The block also keeps the state that the woken core reads after reset:
- two banks of pending bits for the interrupt lines,
- a flag that says the last power-up was a wake from sleep,
- two general-purpose status bits,
- a 3-bit SDRAM protect field. While this field is all ones, the SDRAM clock and clock-enable pins are held in their protected state.

A wake source whose mask bit is set still ends the sleep, but it leaves no pending bit. Lines 0 to 3 report into the main bank and lines 4 to 15 into the external bank. Software reaches the block through one write port: `wr_sel` picks the target and `wr_data` carries the bits.

Top module: `wake_rst_keeper`

## Requirements
- R1: While asleep, a rising edge on any wake line (masked or not) or on the RTC alarm drives `core_rst_n` low. The edge passes through a two-flop synchroniser, so the change shows after the third rising clock edge that follows the input change.
- R2: `core_rst_n` stays low for exactly `RST_CYCLES` clock cycles after the wake takes effect (65535 by default) and then returns high.
- R3: A one-cycle `sleep_req` in the running state drives `pwr_en` low and `core_rst_n` low from the next clock edge. `pwr_en` returns high in the same cycle the reset stretch begins.
- R4: `wake_flag` is set when a wake from sleep takes effect. A write with `wr_sel`=2 and `wr_data[0]`=1 clears it, and so does a cold reset.
- R5: An unmasked rising edge on line i, for i in 0..3, sets `main_pend[i]` and changes no bit of `ext_pend`. This holds in any state, with the same three-edge latency as R1.
- R6: An unmasked rising edge on line i, for i in 4..15, sets `ext_pend[i-4]` and changes no bit of `main_pend`.
- R7: A line whose `wake_mask` bit is 1 still wakes the block from sleep, but its pending bit stays clear.
- R8: A write with `wr_sel`=0 clears each `main_pend[i]` whose `wr_data[i]` is 1. A write with `wr_sel`=1 clears each `ext_pend[i-4]` whose `wr_data[i]` is 1, for i in 4..15. Either change shows after the write's clock edge.
- R9: A write with `wr_sel`=2 loads `gp_bits` from `wr_data[2:1]`. The value survives any number of sleep and wake cycles and is cleared only by a cold reset.
- R10: A write with `wr_sel`=3 loads the protect field from `wr_data[2:0]`. `sdram_prot` is 1 exactly while that field is 3'b111. The field survives sleep and wake until software writes it again.
- R11: Wake-line edges in the running state do not reset the core. `sleep_req` has no effect during the reset stretch.
- R12: While `ext_rst_n` is low, `core_rst_n` is low, `pwr_en` is high, and all pending, flag, status and protect state is zero. The block comes out of cold reset in the running state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on crystal clock |
| ext_rst_n | input | 1 | Cold reset, active low, asynchronous |
| sleep_req | input | 1 | One-cycle request to enter sleep |
| wake_lines | input | 16 | External wake-capable interrupt lines |
| wake_mask | input | 16 | Per-line mask; 1 blocks the pending bit only |
| rtc_alarm | input | 1 | RTC alarm wake source |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 main clear, 1 ext clear, 2 status, 3 protect |
| wr_data | input | 16 | Write data |
| core_rst_n | output | 1 | Reset to the core, active low |
| pwr_en | output | 1 | Core supply enable, high when powered |
| main_pend | output | 4 | Pending bits of lines 0..3 |
| ext_pend | output | 12 | Pending bits of lines 4..15 |
| wake_flag | output | 1 | Last power-up was a wake from sleep |
| gp_bits | output | 2 | Retained general-purpose status |
| sdram_prot | output | 1 | SDRAM clock and clock-enable protection |

## Verification
A line change takes three rising edges to act: two synchroniser flops and the edge-detect register. The bench therefore drives the input at a falling edge and samples the reset, power-enable, flag and pending outputs at the third falling edge after it. A write and a sleep request act on the next rising edge, so they are checked one falling edge later. The bench builds the block with a short stretch. It samples `core_rst_n` one cycle before and at the cycle it is due to return high, which checks the exact length of the stretch.

// File: rtl/wrk_pkg.sv
package wrk_pkg;

   typedef enum logic [1:0] {
      PH_RUN     = 2'd0,
      PH_SLEEP   = 2'd1,
      PH_STRETCH = 2'd2
   } phase_t;

   localparam logic [1:0] SEL_MAIN_CLR = 2'd0;
   localparam logic [1:0] SEL_EXT_CLR  = 2'd1;
   localparam logic [1:0] SEL_STATUS   = 2'd2;
   localparam logic [1:0] SEL_PROT     = 2'd3;

endpackage

// File: rtl/wrk_sync_edge.sv
// Multi-stage synchroniser with rising-edge detection, one lane per input bit.
module wrk_sync_edge #(
   parameter int LANES  = 17,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LANES-1:0] din,
   output logic [LANES-1:0] rise
);

   localparam int DEPTH = STAGES + 1;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("wrk_sync_edge: STAGES must be at least 2");
      end
      if (LANES < 1) begin : g_bad_lanes
         $error("wrk_sync_edge: LANES must be positive");
      end
   endgenerate

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [DEPTH-1:0] pipe;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pipe <= '0;
         end else begin
            pipe <= {pipe[DEPTH-2:0], din[l]};
         end
      end

      // pipe[STAGES-1] is the last synchronised stage, pipe[STAGES] its delay
      assign rise[l] = pipe[STAGES-1] & ~pipe[STAGES];

      AST_NO_DOUBLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
         rise[l] |=> !rise[l]); // R1
   end

endmodule

// File: rtl/wrk_stretch.sv
// Run / sleep / reset-stretch sequencer with the stretch counter.
module wrk_stretch
   import wrk_pkg::*;
#(
   parameter int RST_CYCLES = 65535
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   sleep_req,
   input  logic   wake_any,
   output phase_t phase,
   output logic   stretch_start
);

   localparam int CW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
   localparam logic [CW-1:0] LOAD = CW'(RST_CYCLES - 1);

   generate
      if (RST_CYCLES < 2) begin : g_bad_len
         $error("wrk_stretch: RST_CYCLES must be at least 2");
      end
   endgenerate

   phase_t        phase_q, phase_d;
   logic [CW-1:0] cnt_q, cnt_d;

   always_comb begin
      phase_d       = phase_q;
      cnt_d         = cnt_q;
      stretch_start = 1'b0;
      unique case (phase_q)
         PH_RUN: begin
            if (sleep_req) begin
               phase_d = PH_SLEEP;
            end
         end
         PH_SLEEP: begin
            if (wake_any) begin
               phase_d       = PH_STRETCH;
               cnt_d         = LOAD;
               stretch_start = 1'b1;
            end
         end
         PH_STRETCH: begin
            if (cnt_q == '0) begin
               phase_d = PH_RUN;
            end else begin
               cnt_d = cnt_q - 1'b1;
            end
         end
         default: begin
            phase_d = PH_RUN;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_RUN;
         cnt_q   <= '0;
      end else begin
         phase_q <= phase_d;
         cnt_q   <= cnt_d;
      end
   end

   assign phase = phase_q;

   AST_WAKE_TO_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_SLEEP && wake_any) |=> (phase_q == PH_STRETCH)); // R1
   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_STRETCH) |-> (cnt_q <= LOAD)); // R2
   AST_NO_SLEEP_IN_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_STRETCH) |=> (phase_q != PH_SLEEP)); // R11
   AST_RUN_STAYS_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_RUN && !sleep_req) |=> (phase_q == PH_RUN)); // R11

endmodule

// File: rtl/wrk_pend_bank.sv
// Bank of pending bits: set by unmasked rising edges, cleared by write-one.
module wrk_pend_bank #(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] rise,
   input  logic [WIDTH-1:0] mask,
   input  logic [WIDTH-1:0] clr,
   output logic [WIDTH-1:0] pend
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("wrk_pend_bank: WIDTH must be positive");
      end
   endgenerate

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic hit;
      assign hit = rise[b] & ~mask[b];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend[b] <= 1'b0;
         end else if (hit) begin
            pend[b] <= 1'b1;
         end else if (clr[b]) begin
            pend[b] <= 1'b0;
         end
      end

      AST_MASKED_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
         (mask[b] && !pend[b]) |=> !pend[b]); // R7
      AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
         (clr[b] && !rise[b]) |=> !pend[b]); // R8
   end

endmodule

// File: rtl/wake_rst_keeper.sv
// Always-on wake-up controller with reset stretcher and retained state.
module wake_rst_keeper
   import wrk_pkg::*;
#(
   parameter int N_LINES    = 16,
   parameter int N_MAIN     = 4,
   parameter int RST_CYCLES = 65535,
   parameter int SYNC_STG   = 2,
   parameter int GP_W       = 2,
   parameter int PROT_W     = 3
) (
   input  logic                      clk,
   input  logic                      ext_rst_n,
   input  logic                      sleep_req,
   input  logic [N_LINES-1:0]        wake_lines,
   input  logic [N_LINES-1:0]        wake_mask,
   input  logic                      rtc_alarm,
   input  logic                      wr_en,
   input  logic [1:0]                wr_sel,
   input  logic [N_LINES-1:0]        wr_data,
   output logic                      core_rst_n,
   output logic                      pwr_en,
   output logic [N_MAIN-1:0]         main_pend,
   output logic [N_LINES-N_MAIN-1:0] ext_pend,
   output logic                      wake_flag,
   output logic [GP_W-1:0]           gp_bits,
   output logic                      sdram_prot
);

   localparam int N_EXT = N_LINES - N_MAIN;
   localparam int N_SRC = N_LINES + 1;

   generate
      if (N_MAIN < 1 || N_EXT < 1) begin : g_bad_split
         $error("wake_rst_keeper: both pending banks need at least one line");
      end
      if (N_LINES < GP_W + 1 || N_LINES < PROT_W) begin : g_bad_data
         $error("wake_rst_keeper: write data too narrow for status fields");
      end
   endgenerate

   // ---------------- wake source synchronisation ----------------
   logic [N_SRC-1:0] rise_all;
   logic             wake_any;

   wrk_sync_edge #(.LANES(N_SRC), .STAGES(SYNC_STG)) u_sync (
      .clk   (clk),
      .rst_n (ext_rst_n),
      .din   ({rtc_alarm, wake_lines}),
      .rise  (rise_all)
   );

   assign wake_any = |rise_all;

   // ---------------- phase sequencer ----------------
   phase_t phase;
   logic   stretch_start;

   wrk_stretch #(.RST_CYCLES(RST_CYCLES)) u_seq (
      .clk           (clk),
      .rst_n         (ext_rst_n),
      .sleep_req     (sleep_req),
      .wake_any      (wake_any),
      .phase         (phase),
      .stretch_start (stretch_start)
   );

   assign core_rst_n = ext_rst_n & (phase == PH_RUN);
   assign pwr_en     = (phase != PH_SLEEP);

   // ---------------- write decode ----------------
   logic wr_main, wr_ext, wr_stat, wr_prot;

   always_comb begin
      wr_main = wr_en && (wr_sel == SEL_MAIN_CLR);
      wr_ext  = wr_en && (wr_sel == SEL_EXT_CLR);
      wr_stat = wr_en && (wr_sel == SEL_STATUS);
      wr_prot = wr_en && (wr_sel == SEL_PROT);
   end

   // ---------------- pending banks ----------------
   logic [N_MAIN-1:0] clr_main;
   logic [N_EXT-1:0]  clr_ext;

   assign clr_main = wr_main ? wr_data[N_MAIN-1:0]       : '0;
   assign clr_ext  = wr_ext  ? wr_data[N_LINES-1:N_MAIN] : '0;

   wrk_pend_bank #(.WIDTH(N_MAIN)) u_main_bank (
      .clk   (clk),
      .rst_n (ext_rst_n),
      .rise  (rise_all[N_MAIN-1:0]),
      .mask  (wake_mask[N_MAIN-1:0]),
      .clr   (clr_main),
      .pend  (main_pend)
   );

   wrk_pend_bank #(.WIDTH(N_EXT)) u_ext_bank (
      .clk   (clk),
      .rst_n (ext_rst_n),
      .rise  (rise_all[N_LINES-1:N_MAIN]),
      .mask  (wake_mask[N_LINES-1:N_MAIN]),
      .clr   (clr_ext),
      .pend  (ext_pend)
   );

   // ---------------- retained status ----------------
   logic [PROT_W-1:0] prot_field;

   always_ff @(posedge clk or negedge ext_rst_n) begin
      if (!ext_rst_n) begin
         wake_flag <= 1'b0;
      end else if (stretch_start) begin
         wake_flag <= 1'b1;
      end else if (wr_stat && wr_data[0]) begin
         wake_flag <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge ext_rst_n) begin
      if (!ext_rst_n) begin
         gp_bits <= '0;
      end else if (wr_stat) begin
         gp_bits <= wr_data[GP_W:1];
      end
   end

   always_ff @(posedge clk or negedge ext_rst_n) begin
      if (!ext_rst_n) begin
         prot_field <= '0;
      end else if (wr_prot) begin
         prot_field <= wr_data[PROT_W-1:0];
      end
   end

   assign sdram_prot = &prot_field;

   // ---------------- assertions ----------------
   AST_PWR_UP_IN_RESET: assert property (@(posedge clk) disable iff (!ext_rst_n)
      $rose(pwr_en) |-> !core_rst_n); // R3
   AST_WAKE_FLAG_ON_POWER_UP: assert property (@(posedge clk) disable iff (!ext_rst_n)
      $rose(pwr_en) |-> wake_flag); // R4
   AST_SLEEP_HOLDS_RESET: assert property (@(posedge clk) disable iff (!ext_rst_n)
      !pwr_en |-> !core_rst_n); // R3
   AST_PROT_HOLD: assert property (@(posedge clk) disable iff (!ext_rst_n)
      !wr_prot |=> $stable(sdram_prot)); // R10
   AST_GP_HOLD: assert property (@(posedge clk) disable iff (!ext_rst_n)
      !wr_stat |=> $stable(gp_bits)); // R9

endmodule

// File: tb/wake_rst_keeper_test.sv
`timescale 1ns/100ps
module wake_rst_keeper_test;

   localparam int NL  = 16;
   localparam int NM  = 4;
   localparam int RST = 24;

   logic          clk = 1'b0;
   logic          ext_rst_n;
   logic          sleep_req;
   logic [NL-1:0] wake_lines;
   logic [NL-1:0] wake_mask;
   logic          rtc_alarm;
   logic          wr_en;
   logic [1:0]    wr_sel;
   logic [NL-1:0] wr_data;
   logic          core_rst_n, pwr_en, wake_flag, sdram_prot;
   logic [NM-1:0] main_pend;
   logic [NL-NM-1:0] ext_pend;
   logic [1:0]    gp_bits;

   int checks = 0;
   int failures = 0;
   logic [NM-1:0]    m_main;
   logic [NL-NM-1:0] m_ext;

   always #2.5 clk = ~clk;

   wake_rst_keeper #(.N_LINES(NL), .N_MAIN(NM), .RST_CYCLES(RST)) uut (
      .clk(clk), .ext_rst_n(ext_rst_n), .sleep_req(sleep_req),
      .wake_lines(wake_lines), .wake_mask(wake_mask), .rtc_alarm(rtc_alarm),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .core_rst_n(core_rst_n), .pwr_en(pwr_en), .main_pend(main_pend),
      .ext_pend(ext_pend), .wake_flag(wake_flag), .gp_bits(gp_bits),
      .sdram_prot(sdram_prot)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic logic [NL-1:0] onehot(input int i);
      return NL'(1) << i;
   endfunction

   task automatic cyc(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic reg_write(input logic [1:0] sel, input logic [NL-1:0] data);
      wr_en = 1'b1; wr_sel = sel; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic check_pend(input string req);
      chk(req, "main_pend", int'(main_pend), int'(m_main));
      chk(req, "ext_pend", int'(ext_pend), int'(m_ext));
   endtask

   // model update for an edge on line src (16 = RTC alarm)
   task automatic model_edge(input int src, input bit masked);
      if (src < NM && !masked) m_main[src] = 1'b1;
      else if (src < NL && !masked) m_ext[src-NM] = 1'b1;
   endtask

   task automatic set_src(input int src, input logic v);
      if (src == NL) rtc_alarm = v;
      else wake_lines[src] = v;
   endtask

   // full sleep / wake sequence, inputs driven and sampled at falling edges
   task automatic do_wake(input int src, input bit masked);
      if (src < NL) wake_mask = masked ? onehot(src) : '0;
      sleep_req = 1'b1;
      @(negedge clk);
      sleep_req = 1'b0;
      chk("R3", "pwr_en in sleep", int'(pwr_en), 0);
      chk("R3", "core_rst_n in sleep", int'(core_rst_n), 0);
      set_src(src, 1'b1);
      model_edge(src, masked);
      cyc(3);
      chk("R1", "core_rst_n at wake", int'(core_rst_n), 0);
      chk("R3", "pwr_en at wake", int'(pwr_en), 1);
      chk("R4", "wake_flag at wake", int'(wake_flag), 1);
      check_pend(masked ? "R7" : (src < NM ? "R5" : "R6"));
      set_src(src, 1'b0);
      sleep_req = 1'b1;                  // R11: ignored during the stretch
      @(negedge clk);
      sleep_req = 1'b0;
      cyc(RST - 2);
      chk("R2", "core_rst_n last stretch cycle", int'(core_rst_n), 0);
      @(negedge clk);
      chk("R2", "core_rst_n after stretch", int'(core_rst_n), 1);
      chk("R11", "pwr_en after stretch", int'(pwr_en), 1);
      wake_mask = '0;
      cyc(3);
   endtask

   initial begin
      void'($urandom(32'd4242));
      ext_rst_n = 1'b0; sleep_req = 1'b0; wake_lines = '0; wake_mask = '0;
      rtc_alarm = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
      m_main = '0; m_ext = '0;
      cyc(3);
      chk("R12", "core_rst_n in cold reset", int'(core_rst_n), 0);
      chk("R12", "pwr_en in cold reset", int'(pwr_en), 1);
      ext_rst_n = 1'b1;
      @(negedge clk);
      chk("R12", "core_rst_n after cold reset", int'(core_rst_n), 1);
      chk("R12", "wake_flag after cold reset", int'(wake_flag), 0);
      chk("R12", "sdram_prot after cold reset", int'(sdram_prot), 0);
      check_pend("R12");

      // R11 / R5: edge while running sets pending but no reset
      wake_lines[2] = 1'b1; model_edge(2, 1'b0);
      cyc(3);
      chk("R11", "core_rst_n on run edge", int'(core_rst_n), 1);
      check_pend("R5");
      wake_lines[2] = 1'b0; cyc(3);

      // R9 / R10: status and protection
      reg_write(2'd2, 16'b100);
      chk("R9", "gp_bits written", int'(gp_bits), 2);
      reg_write(2'd3, 16'b110);
      chk("R10", "sdram_prot at 110", int'(sdram_prot), 0);
      reg_write(2'd3, 16'b111);
      chk("R10", "sdram_prot at 111", int'(sdram_prot), 1);

      do_wake(9, 1'b0);                   // R6
      chk("R9", "gp_bits after wake", int'(gp_bits), 2);
      chk("R10", "sdram_prot after wake", int'(sdram_prot), 1);
      reg_write(2'd3, 16'b000);
      chk("R10", "sdram_prot released", int'(sdram_prot), 0);

      do_wake(1, 1'b1);                   // R7 masked line still wakes
      do_wake(NL, 1'b0);                  // R1 RTC alarm
      do_wake(0, 1'b0);                   // R5

      // R8 clears
      reg_write(2'd0, onehot(2)); m_main[2] = 1'b0;
      check_pend("R8");
      reg_write(2'd1, onehot(9)); m_ext[9-NM] = 1'b0;
      check_pend("R8");
      reg_write(2'd2, 16'b101);           // R4 clear flag, keep gp=2
      chk("R4", "wake_flag cleared", int'(wake_flag), 0);
      chk("R9", "gp_bits rewritten", int'(gp_bits), 2);

      // constrained random wakes and clears
      for (int it = 0; it < 16; it++) begin
         int src;
         bit msk;
         src = int'($urandom % (NL + 1));
         msk = ($urandom % 3) == 0;
         do_wake(src, msk);
         if ($urandom % 2) begin
            logic [NL-1:0] c;
            c = NL'($urandom);
            reg_write(2'd0, c); m_main &= ~c[NM-1:0];
            check_pend("R8");
            reg_write(2'd1, c); m_ext &= ~c[NL-1:NM];
            check_pend("R8");
         end
      end

      // R12 / R4 / R9: cold reset wipes retained state
      reg_write(2'd3, 16'b111);
      ext_rst_n = 1'b0;
      #1;
      chk("R12", "core_rst_n async", int'(core_rst_n), 0);
      chk("R4", "wake_flag cold cleared", int'(wake_flag), 0);
      chk("R9", "gp_bits cold cleared", int'(gp_bits), 0);
      chk("R10", "sdram_prot cold cleared", int'(sdram_prot), 0);
      @(negedge clk);
      ext_rst_n = 1'b1;
      @(negedge clk);
      m_main = '0; m_ext = '0;
      check_pend("R12");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule